// File: doc/BRIEF.md
# Memory Min/Max Finder

This block holds a small table of unsigned values and, on request, walks through every entry to find the smallest and the largest one. Software or a neighbouring block first fills the table through a valid/ready write port, then pulses a start input. The block reports the two results on plain output buses and raises a done flag when the scan has finished. The results stay on the outputs until the next scan is launched.

Only one magnitude comparator is used. It is shared in time: each entry after the first gets one cycle compared against the running maximum and one cycle compared against the running minimum. A single index counter both addresses the table and counts the iterations. The loop is closed by a look-ahead test on the index, made while the last entry is still being compared, so the counter never wraps back to zero.

Write-port rules: a write is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only while no scan is running (after reset and while done is shown). While it is low the write is not taken and the table is left unchanged. Holding `wr_valid` high with stable address and data until `wr_ready` is seen high is the sender's responsibility.

Top module: `mm_finder`

## Requirements
- R1: After reset `done` is 0, `min_val` and `max_val` are 0, and `wr_ready` is 1.
- R2: A table write happens only on an edge where `wr_valid` and `wr_ready` are both 1. Entry number `wr_addr` (0 to 15) takes `wr_data`. `wr_ready` is 0 for the whole of a scan.
- R3: A `start` pulse seen while the block is idle or done launches a scan. A `start` seen while a scan is running has no effect on the scan or its timing.
- R4: The first scan cycle loads entry 0 into both the running minimum and the running maximum. In the same cycle the index moves to 1.
- R5: For entries 1 to 15, the maximum takes an entry only when the entry is strictly greater than it, and the minimum takes an entry only when the entry is strictly smaller. Equal values leave both unchanged.
- R6: The comparator is shared, so each of entries 1 to 15 costs two cycles. `done` goes high after exactly 32 rising edges, counting the edge that samples `start` as the first.
- R7: The scan ends after entry 15 is compared, with no wrap of the index. While `done` is 1 and `start` is 0, `done`, `min_val` and `max_val` do not change.
- R8: A `start` seen while `done` is 1 begins a new scan. `done` falls after that edge, and the new results reflect the current table contents.
- R9: Write attempts made during a scan are not taken. A later scan over the same table gives the same results.
- R10: Extreme values are found wherever they sit: 0 and 15 in entry 0 or in entry 15 are reported correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a scan |
| wr_valid | input | 1 | Table write request |
| wr_ready | output | 1 | Table can accept a write (no scan running) |
| wr_addr | input | 4 | Entry number to write |
| wr_data | input | 4 | Unsigned value to write |
| min_val | output | 4 | Smallest value found by the last scan |
| max_val | output | 4 | Largest value found by the last scan |
| done | output | 1 | Scan finished; results valid |

## Verification
The bench counts the exact number of edges from start to done. A design that spends an extra cycle on the exit test, or that skips the second compare for an entry, gives a different count. Extremes placed in entry 0 and in entry 15 catch a first load that is missed or a loop that exits one entry early. An all-equal table catches a compare that is not strict. Start pulses and write attempts made in the middle of a scan, followed by a repeat scan, expose a control unit that restarts when it should not and a table that accepts writes while `wr_ready` is low. Holding in done for several cycles shows whether the index wraps and starts a false second pass.

// File: rtl/mm_finder_pkg.sv
package mm_finder_pkg;
  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_LOAD = 2'd1,
    ST_COMP = 2'd2,
    ST_DONE = 2'd3
  } mm_state_e;

  typedef enum logic {
    PH_MAX = 1'b0,
    PH_MIN = 1'b1
  } mm_phase_e;
endpackage

// File: rtl/mm_store.sv
module mm_store #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/mm_index_cntr.sv
module mm_index_cntr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  output logic [ADDR_W-1:0] idx,
  output logic              last
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (en)  idx <= idx + 1'b1;
  end

  assign last = (idx == TOP);

  // The control unit must never request an increment at the top index.
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |-> !last); // R7
endmodule

// File: rtl/mm_cmp.sv
module mm_cmp #(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              gt,
  output logic              lt
);
  assign gt = (a > b);
  assign lt = (a < b);
endmodule

// File: rtl/mm_datapath.sv
module mm_datapath #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] entry,
  input  logic              init_load,
  input  logic              cmp_active,
  input  logic              sel_min,
  output logic [DATA_W-1:0] min_q,
  output logic [DATA_W-1:0] max_q
);
  logic [DATA_W-1:0] ref_val;
  logic              is_gt;
  logic              is_lt;
  logic              take_max;
  logic              take_min;

  assign ref_val = sel_min ? min_q : max_q;

  mm_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a  (entry),
    .b  (ref_val),
    .gt (is_gt),
    .lt (is_lt)
  );

  assign take_max = init_load || (cmp_active && !sel_min && is_gt);
  assign take_min = init_load || (cmp_active &&  sel_min && is_lt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= '0;
      min_q <= '0;
    end else begin
      if (take_max) max_q <= entry;
      if (take_min) min_q <= entry;
    end
  end

  AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    init_load |=> (max_q == min_q)); // R4
  AST_MAX_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_active && !init_load) |=> (max_q >= $past(max_q))); // R5
  AST_MIN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_active && !init_load) |=> (min_q <= $past(min_q))); // R5
  AST_MIN_PHASE_KEEPS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_active && sel_min) |=> $stable(max_q)); // R5
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_finder_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last_idx,
  output logic cnt_clr,
  output logic cnt_en,
  output logic init_load,
  output logic cmp_active,
  output logic sel_min,
  output logic idle,
  output logic done
);
  mm_state_e state_q, state_d;
  mm_phase_e phase_q, phase_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    unique case (state_q)
      ST_INIT: if (start) state_d = ST_LOAD;
      ST_LOAD: begin
        state_d = ST_COMP;
        phase_d = PH_MAX;
      end
      ST_COMP: begin
        if (phase_q == PH_MAX) begin
          phase_d = PH_MIN;
        end else begin
          phase_d = PH_MAX;
          if (last_idx) state_d = ST_DONE;
        end
      end
      ST_DONE: if (start) state_d = ST_LOAD;
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      phase_q <= PH_MAX;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  assign idle       = (state_q == ST_INIT) || (state_q == ST_DONE);
  assign done       = (state_q == ST_DONE);
  assign cnt_clr    = idle;
  assign init_load  = (state_q == ST_LOAD);
  assign cmp_active = (state_q == ST_COMP);
  assign sel_min    = (phase_q == PH_MIN);
  assign cnt_en     = init_load || (cmp_active && sel_min && !last_idx);

  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> (state_q == ST_LOAD)); // R3
  AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_active && !(sel_min && last_idx)) |=> (state_q == ST_COMP)); // R3
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R7
  AST_EXIT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_active && sel_min && last_idx) |=> done); // R6
endmodule

// File: rtl/mm_finder.sv
module mm_finder #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] min_val,
  output logic [DATA_W-1:0] max_val,
  output logic              done
);
  logic              cnt_clr;
  logic              cnt_en;
  logic              init_load;
  logic              cmp_active;
  logic              sel_min;
  logic              idle;
  logic              last_idx;
  logic [ADDR_W-1:0] idx;
  logic [DATA_W-1:0] entry;
  logic              wr_fire;

  assign wr_ready = idle;
  assign wr_fire  = wr_valid && wr_ready;

  mm_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .last_idx   (last_idx),
    .cnt_clr    (cnt_clr),
    .cnt_en     (cnt_en),
    .init_load  (init_load),
    .cmp_active (cmp_active),
    .sel_min    (sel_min),
    .idle       (idle),
    .done       (done)
  );

  mm_index_cntr #(.ADDR_W(ADDR_W)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .idx   (idx),
    .last  (last_idx)
  );

  mm_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (idx),
    .rdata (entry)
  );

  mm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry      (entry),
    .init_load  (init_load),
    .cmp_active (cmp_active),
    .sel_min    (sel_min),
    .min_q      (min_val),
    .max_q      (max_val)
  );

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(min_val) && $stable(max_val))); // R7
  AST_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (min_val <= max_val)); // R5
  AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done); // R8
endmodule

// File: tb/mm_finder_test.sv
`timescale 1ns/1ps
module mm_finder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [3:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [3:0] min_val;
  logic [3:0] max_val;
  logic       done;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mm_finder uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .min_val  (min_val),
    .max_val  (max_val),
    .done     (done)
  );

  // Each vector: [71:8] table, entry i in bits 4i+11:4i+8; [7:4] min; [3:0] max.
  localparam int NVEC = 5;
  localparam logic [71:0] VEC [NVEC] = '{
    {64'hFEDC_BA98_7654_3210, 4'h0, 4'hF},
    {64'h0123_4567_89AB_CDEF, 4'h0, 4'hF},
    {64'h7777_7777_7777_7777, 4'h7, 4'h7},
    {64'h5938_4726_9A35_8B44, 4'h2, 4'hB},
    {64'h1888_8888_8888_8888, 4'h1, 4'h8}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input logic [63:0] tbl);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_addr  = 4'(i);
      wr_data  = tbl[4*i +: 4];
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic scan(output int lat);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lat;
    logic [3:0] mn, mx;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", int'(done), 0);
    check("R1 min", int'(min_val), 0);
    check("R1 max", int'(max_val), 0);
    check("R1 wr_ready", int'(wr_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      fill(VEC[v][71:8]);
      scan(lat);
      check("R6 latency", lat, 32);
      check("R4 R10 min", int'(min_val), int'(VEC[v][7:4]));
      check("R5 R10 max", int'(max_val), int'(VEC[v][3:0]));
      check("R7 done", int'(done), 1);
    end

    // R7: hold in done, results and done stay put, no wrap into a new pass
    repeat (40) @(negedge clk);
    check("R7 done held", int'(done), 1);
    check("R7 min held", int'(min_val), 1);
    check("R7 max held", int'(max_val), 8);

    // R3, R2, R9: disturb a running scan over table V3
    fill(VEC[3][71:8]);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    check("R8 done falls", int'(done), 0);
    repeat (5) begin @(posedge clk); lat++; @(negedge clk); end
    check("R2 ready low in scan", int'(wr_ready), 0);
    start    = 1'b1;
    wr_valid = 1'b1;
    wr_addr  = 4'd9;
    wr_data  = 4'hF;
    @(posedge clk); lat++;
    @(negedge clk);
    wr_addr = 4'd0;
    wr_data = 4'h0;
    @(posedge clk); lat++;
    @(negedge clk);
    start    = 1'b0;
    wr_valid = 1'b0;
    while (!done && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    check("R3 latency unchanged", lat, 32);
    check("R3 min", int'(min_val), 2);
    check("R3 max", int'(max_val), 11);
    mn = min_val;
    mx = max_val;
    scan(lat);
    check("R9 min repeat", int'(min_val), int'(mn));
    check("R9 max repeat", int'(max_val), int'(mx));
    check("R8 restart latency", lat, 32);

    // R8: change one entry while done, restart picks it up
    @(negedge clk);
    check("R2 ready in done", int'(wr_ready), 1);
    wr_valid = 1'b1;
    wr_addr  = 4'd15;
    wr_data  = 4'hF;
    @(negedge clk);
    wr_valid = 1'b0;
    scan(lat);
    check("R8 new max", int'(max_val), 15);
    check("R8 min kept", int'(min_val), 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule